// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the bus-facing half of a 2048-byte non-volatile memory on a two-wire serial bus. It runs on a fast system clock and oversamples the serial clock and data lines. It finds START and STOP conditions and decodes a slave byte that carries a fixed four-bit device code, the three upper memory-address bits and a direction bit. It acknowledges or refuses each byte by pulling the data line low through an open-drain style output. The storage is an internal byte array that can be inferred as block RAM.

Writes go into a 16-byte page buffer and are committed only when the master ends the transfer with STOP. A program window follows, lasting a set number of clock cycles. For that whole window the block ignores the bus, so the master can poll with its slave address until it is acknowledged. Reads use an address counter that points one past the last byte accessed. The master can read from the current counter, set the counter with an address-only write and then repeat START for a random read, or keep acknowledging to read sequentially. A write-protect input and a lock input (an active system reset or a supply lock-out) block writes and all access, respectively.

Top module: `sermem_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Until a START is seen, clocked bits are ignored and no acknowledge is given. The output is released after reset.
- R2: The slave byte is sent MSB first as device code 4'b1010, then address bits 10..8, then R/W (1 = read, 0 = write). It is acknowledged in the ninth clock only when the code matches. Any other code gets no acknowledge. A write slave byte loads address bits 10..8 into the address counter.
- R3: A write is the slave byte, then one byte holding address bits 7..0, then data bytes. Each byte is acknowledged, and programming starts only on STOP.
- R4: After each data byte only address bits 3..0 increment, inside a 16-byte page. More than 16 data bytes wrap within the page, and later bytes overwrite earlier ones.
- R5: From a STOP that ends a write with data until PROG_CYCLES clocks later, no slave byte is acknowledged. After that window the next slave byte is acknowledged.
- R6: With wp_i high, the slave byte and the address byte are acknowledged, but the first data byte is not. Nothing is programmed and no program window follows.
- R7: A read slave byte leaves the address counter unchanged, so a current-address read returns the byte one past the last one accessed.
- R8: A random read is an address-only write followed by a repeated START and a read slave byte. It returns the byte at the address that was set.
- R9: In a read, each master acknowledge causes the next byte to be sent. The counter steps through all 11 bits and wraps from 2047 to 0.
- R10: If the master does not acknowledge a read byte, the transfer ends. The device leaves SDA released until the next START or STOP.
- R11: While lock_i is high, nothing is acknowledged. Lock discards any unprogrammed page data, so the STOP that follows starts no program window.
- R12: A STOP before any data byte starts no program window. The address-only write still sets the address counter.
- R13: Read data goes out MSB first. sda_pull_o changes only while SCL is low, and it is released during the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| lock_i | input | 1 | Reset or supply lock-out active; blocks all access |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain drive) |

## Verification
The write path is tested three ways: a single-byte write, an 18-byte burst that starts two bytes before the end of its page, and an address-only write. Only the burst shows whether the increment stays inside the page, and only the address-only write shows whether a program window starts without data. Reads are tested as current-address, random, sequential across the 2047-to-0 boundary, and a read the master ends with no acknowledge. Together these show whether the counter advances by the page rule or by the full-width rule. Write-protect, lock raised in the middle of a write, and a wrong device code each test a different refusal point: the first data byte, every byte and pending data, and the slave byte.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADDR,
    S_WDATA,
    S_READ,
    S_MACK,
    S_WAIT,
    S_BUSY
  } state_t;

endpackage

// File: rtl/sermem_busfront.sv
module sermem_busfront #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N-1:0] scl_m, sda_m;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= '1;
      sda_m <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[SYNC_N-2:0], scl_i};
      sda_m <= {sda_m[SYNC_N-2:0], sda_i};
      scl_q <= scl_m[SYNC_N-1];
      sda_q <= sda_m[SYNC_N-1];
    end
  end

  assign scl_s    = scl_m[SYNC_N-1];
  assign sda_s    = sda_m[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // data edges while the clock stays high are framing conditions
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sermem_store.sv
module sermem_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sermem_fsm.sv
module sermem_fsm
  import sermem_pkg::*;
#(
  parameter int          ADDR_W      = 11,
  parameter int          PAGE_W      = 4,
  parameter int          PROG_CYCLES = 2000,
  parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_i,
  input  logic              wp_i,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              sda_pull_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BYTES);

  state_t state, nxt;
  logic [3:0]               bitcnt;
  logic                     in_ack;
  logic [7:0]               sh, txsh;
  logic                     mack_ok;
  logic [ADDR_W-1:0]        ptr;
  logic [ADDR_W-PAGE_W-1:0] page_hi;
  logic [7:0]               pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    vld;
  logic [CNT_W-1:0]         busy_cnt;
  logic [PAGE_W-1:0]        cidx;

  assign cidx      = busy_cnt[PAGE_W-1:0];
  assign rd_addr_o = ptr;
  assign busy_o    = (state == S_BUSY);
  // the first PAGE_BYTES cycles of the program window drain the page buffer
  assign wr_en_o   = busy_o && (busy_cnt < CNT_PAGE) && vld[cidx];
  assign wr_addr_o = {page_hi, cidx};
  assign wr_data_o = pbuf[cidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      nxt        <= S_IDLE;
      bitcnt     <= '0;
      in_ack     <= 1'b0;
      sh         <= '0;
      txsh       <= '0;
      mack_ok    <= 1'b0;
      ptr        <= '0;
      page_hi    <= '0;
      vld        <= '0;
      busy_cnt   <= '0;
      sda_pull_o <= 1'b0;
    end else if (lock_i) begin
      state      <= S_IDLE;
      in_ack     <= 1'b0;
      vld        <= '0;
      busy_cnt   <= '0;
      sda_pull_o <= 1'b0;
    end else if (state == S_BUSY) begin
      if (busy_cnt == CNT_LAST) begin
        state    <= S_IDLE;
        vld      <= '0;
        busy_cnt <= '0;
      end else begin
        busy_cnt <= busy_cnt + CNT_W'(1);
      end
    end else if (start_ev) begin
      state      <= S_DEV;
      bitcnt     <= '0;
      in_ack     <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_ev) begin
      in_ack     <= 1'b0;
      sda_pull_o <= 1'b0;
      busy_cnt   <= '0;
      state      <= (|vld) ? S_BUSY : S_IDLE;
    end else if (in_ack) begin
      if (scl_fall) begin
        in_ack <= 1'b0;
        bitcnt <= '0;
        state  <= nxt;
        if (nxt == S_READ) begin
          txsh       <= rd_data_i;
          sda_pull_o <= ~rd_data_i[7];
        end else begin
          sda_pull_o <= 1'b0;
        end
      end
    end else begin
      case (state)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            if (state == S_DEV) begin
              if (sh[7:4] == DEV_CODE) begin
                in_ack     <= 1'b1;
                sda_pull_o <= 1'b1;
                if (sh[0]) begin
                  nxt <= S_READ;
                end else begin
                  nxt              <= S_WADDR;
                  ptr[ADDR_W-1:8]  <= sh[HI_W:1];
                end
              end else begin
                state <= S_WAIT;
              end
            end else if (state == S_WADDR) begin
              ptr[7:0]   <= sh;
              in_ack     <= 1'b1;
              sda_pull_o <= 1'b1;
              nxt        <= S_WDATA;
            end else begin
              if (wp_i) begin
                state <= S_WAIT;
              end else begin
                pbuf[ptr[PAGE_W-1:0]] <= sh;
                vld[ptr[PAGE_W-1:0]]  <= 1'b1;
                page_hi               <= ptr[ADDR_W-1:PAGE_W];
                ptr[PAGE_W-1:0]       <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                in_ack                <= 1'b1;
                sda_pull_o            <= 1'b1;
                nxt                   <= S_WDATA;
              end
            end
          end
        end
        S_READ: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              ptr        <= ptr + ADDR_W'(1);
              state      <= S_MACK;
            end else begin
              sda_pull_o <= ~txsh[3'd7 - bitcnt[2:0]];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              state      <= S_READ;
              bitcnt     <= '0;
              txsh       <= rd_data_i;
              sda_pull_o <= ~rd_data_i[7];
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_W      = 4,
  parameter int         PROG_CYCLES = 2000,
  parameter int         SYNC_N      = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic lock_i,
  output logic sda_pull_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              st_we;
  logic [ADDR_W-1:0] st_waddr;
  logic [7:0]        st_wdata;
  logic              busy_w;

  sermem_busfront #(.SYNC_N(SYNC_N)) front_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  sermem_fsm #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES), .DEV_CODE(DEV_CODE)
  ) fsm_i (
    .clk(clk), .rst(rst), .lock_i(lock_i), .wp_i(wp_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(st_we), .wr_addr_o(st_waddr), .wr_data_o(st_wdata),
    .busy_o(busy_w), .sda_pull_o(sda_pull_o)
  );

  sermem_store #(.ADDR_W(ADDR_W), .DATA_W(8)) store_i (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/sermem_chk.sv
module sermem_chk (
  input logic clk,
  input logic rst,
  input logic lock_i,
  input logic sda_pull,
  input logic busy,
  input logic scl_s,
  input logic stop_ev
);
  // R11
  lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> !sda_pull);

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull);

  // R3
  prog_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));

  // R13
  sda_low_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_pull) && !$past(lock_i)) |-> !$past(scl_s));
endmodule

bind sermem_slave sermem_chk chk_i (
  .clk(clk), .rst(rst), .lock_i(lock_i), .sda_pull(sda_pull_o),
  .busy(busy_w), .scl_s(scl_s), .stop_ev(stop_ev)
);

// File: tb/sermem_slave_tb.sv
`timescale 1ns/1ps
module sermem_slave_tb_top;
  localparam int Q    = 8;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst, scl, m_sda, wp, lock;
  logic pull;
  wire  sda_line = m_sda & ~pull;

  always #2.5 clk = ~clk;

  sermem_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .lock_i(lock), .sda_pull_o(pull)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] model [2048];
  logic [7:0] exp_q [$];
  logic [7:0] obs_q [$];
  string      tag_q [$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(o === e, t, o, e);
    end
  end

  task automatic bw(int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1'b1; bw(Q); scl = 1'b1; bw(Q); m_sda = 1'b0; bw(Q); scl = 1'b0; bw(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; bw(Q); scl = 1'b1; bw(Q); m_sda = 1'b1; bw(2*Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; bw(Q); scl = 1'b1; bw(2*Q); scl = 1'b0; bw(Q);
    end
    m_sda = 1'b1; bw(Q); scl = 1'b1; bw(Q);
    ack = (sda_line == 1'b0);
    bw(Q); scl = 1'b0; bw(Q);
  endtask

  task automatic recv_byte(bit give_ack);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bw(Q); scl = 1'b1; bw(Q); b[i] = sda_line; bw(Q); scl = 1'b0;
    end
    bw(Q); m_sda = give_ack ? 1'b0 : 1'b1;
    bw(Q); scl = 1'b1; bw(2*Q); scl = 1'b0; bw(Q); m_sda = 1'b1;
    obs_q.push_back(b);
  endtask

  function automatic logic [7:0] slv(logic [10:0] a, bit rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic expect_byte(logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic poll(output int tries, output bit acked);
    bit a;
    tries = 0; acked = 0;
    for (int k = 0; k < 40; k++) begin
      do_start; send_byte(8'hA0, a); do_stop;
      tries++;
      if (a) begin acked = 1; break; end
    end
  endtask

  task automatic write_burst(logic [10:0] a, int n, logic [7:0] seed);
    bit ack; int tries; bit acked;
    do_start;
    send_byte(slv(a, 0), ack); chk(ack, "R3 slave byte ack", ack, 1);
    send_byte(a[7:0], ack);    chk(ack, "R3 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [3:0] idx;
      d = seed + 8'(i * 17);
      idx = a[3:0] + 4'(i);
      send_byte(d, ack); chk(ack, "R3 data ack", ack, 1);
      model[{a[10:4], idx}] = d;   // R4 page wrap model
    end
    do_stop;
    poll(tries, acked);
    chk(tries > 1, "R5 first poll refused", tries, 2);
    chk(acked, "R5 ack after program window", acked, 1);
  endtask

  task automatic read_seq(logic [10:0] a, int n, string tag);
    bit ack;
    do_start;
    send_byte(slv(a, 0), ack); chk(ack, "R8 dummy write ack", ack, 1);
    send_byte(a[7:0], ack);    chk(ack, "R8 address ack", ack, 1);
    do_start;
    send_byte(slv(a, 1), ack); chk(ack, "R8 read slave ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      expect_byte(model[11'(a + 11'(i))], tag);
      recv_byte(i < n - 1);
    end
    do_stop;
  endtask

  initial begin
    bit ack; int tries; bit acked;
    scl = 1'b1; m_sda = 1'b1; wp = 1'b0; lock = 1'b0; rst = 1'b1;
    bw(10); rst = 1'b0; bw(5);
    chk(pull == 1'b0, "R1 released after reset", pull, 0);

    // R1: bits with no START are ignored
    scl = 1'b0; bw(Q);
    send_byte(8'hA0, ack); chk(!ack, "R1 no ack without START", ack, 0);
    do_stop;

    // R2: wrong device code
    do_start; send_byte(8'hB0, ack); chk(!ack, "R2 wrong code refused", ack, 0); do_stop;

    // R3 / R5 byte write
    write_burst(11'h123, 1, 8'h5A);

    // R12 address-only write, then immediate current-address read
    do_start; send_byte(slv(11'h123, 0), ack); send_byte(8'h23, ack); do_stop;
    do_start; send_byte(8'hA1, ack); chk(ack, "R12 no program window", ack, 1);
    expect_byte(model[11'h123], "R12/R7 counter set");
    recv_byte(0); do_stop;

    // R4 page wrap: 18 bytes from 0x50E
    write_burst(11'h50E, 18, 8'h40);
    read_seq(11'h500, 16, "R4/R13 page data");

    // R7 current address after a random read
    read_seq(11'h503, 1, "R8 random read");
    do_start; send_byte(8'hA1, ack); chk(ack, "R7 read ack", ack, 1);
    expect_byte(model[11'h504], "R7 current address");
    recv_byte(0); do_stop;

    // R9 wrap across the top address
    write_burst(11'h7FF, 1, 8'hC3);
    write_burst(11'h000, 1, 8'h3C);
    read_seq(11'h7FF, 2, "R9 sequential wrap");

    // R6 write protect
    wp = 1'b1;
    do_start;
    send_byte(slv(11'h504, 0), ack); chk(ack, "R6 slave byte ack", ack, 1);
    send_byte(8'h04, ack);           chk(ack, "R6 address ack", ack, 1);
    send_byte(8'hEE, ack);           chk(!ack, "R6 data refused", ack, 0);
    do_stop; wp = 1'b0;
    poll(tries, acked); chk(tries == 1, "R6 no program window", tries, 1);
    read_seq(11'h504, 1, "R6 data unchanged");

    // R10 master NACK ends the read
    do_start; send_byte(slv(11'h500, 0), ack); send_byte(8'h00, ack);
    do_start; send_byte(slv(11'h500, 1), ack);
    expect_byte(model[11'h500], "R10 byte before NACK");
    recv_byte(0);
    expect_byte(8'hFF, "R10 released after NACK");
    recv_byte(0);
    do_stop;

    // R11 lock refuses access and drops pending data
    lock = 1'b1; bw(4);
    do_start; send_byte(8'hA0, ack); chk(!ack, "R11 no ack under lock", ack, 0); do_stop;
    lock = 1'b0; bw(4);
    write_burst(11'h600, 1, 8'h22);
    do_start; send_byte(slv(11'h600, 0), ack); send_byte(8'h00, ack);
    send_byte(8'h99, ack); chk(ack, "R11 data ack before lock", ack, 1);
    lock = 1'b1; bw(4); lock = 1'b0; bw(4);
    do_stop;
    poll(tries, acked); chk(tries == 1, "R11 no program window after lock", tries, 1);
    read_seq(11'h600, 1, "R11 pending data dropped");

    bw(20);
    chk(exp_q.size() == 0 && obs_q.size() == 0, "R13 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule